// File: doc/BRIEF.md
# Resolution-Selectable Serial Converter Host Controller

This block is the host side of a two-wire link to a serial sigma-delta converter. The link has one clock line driven by the host and one data line driven by the converter. When `cmd_start` arrives, the controller drives the requested 2-bit channel onto the address pins. It then pulls the clock low to begin a conversion. Right after that start edge, it adds extra falling edges that lower the converter's resolution: one edge per bit removed, with the request clamped to 10..16 bits. It then holds the clock high and waits for the converter to raise the data line. After that it clocks the two's-complement result in, one bit per falling edge. The result is presented right-aligned and sign-extended to 16 bits, together with a one-cycle valid strobe.

Every clock phase lasts `max(half_period, MIN_HALF)` system cycles. This keeps each pulse wider than the converter's input glitch filter. A timeout counter limits how long the controller waits for completion. A resynchronization command toggles the clock and watches the data line at the high, low and high points of each period. The search stops when it sees the 1-1-0 pattern that marks a freshly started conversion. The controller then reads that conversion at full 16-bit resolution.

The states are `ST_IDLE`, `ST_SETUP`, `ST_START_LO`, `ST_RED_HI`, `ST_RED_LO`, `ST_WAIT`, `ST_RD_LO`, `ST_RD_HI`, `ST_DONE`, `ST_RS_HI0`, `ST_RS_LO` and `ST_RS_HI`. The transitions are:

- IDLE→SETUP on start.
- IDLE→RS_HI0 on resync, when there is no start.
- SETUP→START_LO, START_LO→RED_HI and RED_LO→RED_HI at the end of each phase.
- RED_HI→RED_LO while reduction edges remain, otherwise RED_HI→WAIT.
- WAIT→RD_LO when the data line is high.
- WAIT→IDLE on timeout.
- RD_LO→RD_HI at the end of the phase.
- RD_HI→RD_LO while bits remain, otherwise RD_HI→DONE.
- DONE→IDLE.
- RS_HI0→RS_LO and RS_LO→RS_HI at the end of each phase.
- RS_HI→WAIT on the 1-1-0 pattern, otherwise RS_HI→RS_LO.
- Any RS state→IDLE on timeout.

Top module: `adc_host_ctrl`

## Requirements
- R1: Out of reset, and after every finished or aborted transaction, `adc_sclk` is 1 and `busy` is 0.
- R2: The channel from `cmd_chan` is driven on `adc_addr` before the start falling edge. It stays unchanged until `busy` falls.
- R3: After the start edge, the controller issues 16 − n extra falling edges, where n is the effective resolution.
- R4: The effective resolution n is `cmd_res` clamped to the range 10..16. Values below 10 give 10 and values above 16 give 16, so at most 6 reduction edges are sent.
- R5: Readout begins only after `adc_sdat` is seen high with the clock high. n bits are then read, one per falling edge. Each bit is sampled at the end of its low phase, sign bit first and LSB last.
- R6: A transaction started by `cmd_start` produces exactly 17 falling edges of `adc_sclk` in total.
- R7: `rslt_data` holds the n-bit result right-aligned, with bits 15..n copies of bit n−1. `rslt_valid` is high for exactly one cycle per result.
- R8: `rslt_bad` is 1 together with `rslt_valid` exactly when the n-bit code is the most negative code, a 1 followed by n−1 zeros (0x8000 for n = 16).
- R9: Every high or low phase of `adc_sclk` inside a transaction lasts exactly `max(half_period, MIN_HALF)` cycles.
- R10: If `adc_sdat` does not go high within `timeout_limit` cycles of entering the wait, `tmo_err` pulses for one cycle. The controller then returns to idle with the clock high and gives no result.
- R11: During a resync, the controller keeps toggling the clock until the samples at the high, low and high points read 1, 1, 0. It then pulses `sync_found` and reads a 16-bit result.
- R12: `cmd_start` and `cmd_resync` are ignored while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_start | input | 1 | Begin a convert-and-read transaction |
| cmd_resync | input | 1 | Begin a resynchronization search |
| cmd_chan | input | 2 | Channel to convert |
| cmd_res | input | 5 | Requested resolution in bits |
| half_period | input | HP_W | Clock half-period in system cycles |
| timeout_limit | input | TO_W | Completion wait limit in cycles |
| adc_sclk | output | 1 | Serial clock to the converter |
| adc_addr | output | 2 | Channel address pins |
| adc_sdat | input | 1 | Serial data line from the converter |
| busy | output | 1 | Transaction in progress |
| rslt_data | output | DATA_W | Sign-extended result |
| rslt_valid | output | 1 | One-cycle result strobe |
| rslt_bad | output | 1 | Result is the reserved code |
| tmo_err | output | 1 | One-cycle timeout strobe |
| sync_found | output | 1 | One-cycle resync lock strobe |

## Verification
`rslt_valid` and `rslt_bad` rise on the cycle after the final readout high phase ends. `tmo_err` rises `timeout_limit` plus one or two cycles after the wait is entered. `adc_addr` changes one cycle after a start is accepted. Clock phases follow the programmed width exactly. The bench drives all inputs on falling edges and samples on falling edges. It waits for each strobe with a bounded poll and does not predict a fixed cycle, because the converter model's delays vary. Phase widths are measured cycle by cycle, and the edge count is checked against a running falling-edge counter.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_START_LO,
        ST_RED_HI,
        ST_RED_LO,
        ST_WAIT,
        ST_RD_LO,
        ST_RD_HI,
        ST_DONE,
        ST_RS_HI0,
        ST_RS_LO,
        ST_RS_HI
    } host_st_e;
endpackage

// File: rtl/adc_host_phase_timer.sv
module adc_host_phase_timer #(
    parameter int HP_W     = 16,
    parameter int MIN_HALF = 188
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [HP_W-1:0] half_period,
    output logic            expired
);
    localparam logic [HP_W-1:0] FLOOR = HP_W'(MIN_HALF);

    logic [HP_W-1:0] span;
    logic [HP_W-1:0] cnt;

    assign span = (half_period < FLOOR) ? FLOOR : half_period;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= span - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

    // R9: a freshly loaded phase never runs shorter than the floor
    assert_span_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt >= FLOOR - 1'b1));
endmodule

// File: rtl/adc_host_timeout.sv
module adc_host_timeout #(
    parameter int TO_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            en,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);
    logic [TO_W-1:0] cnt;

    assign expired = (cnt >= limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && !expired)
            cnt <= cnt + 1'b1;
    end

    // R10: the counter stops once the limit is reached
    assert_tmo_sat_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !clr) |=> $stable(cnt));
endmodule

// File: rtl/adc_host_shifter.sv
module adc_host_shifter #(
    parameter int DATA_W = 16,
    parameter int NB_W   = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              shift_en,
    input  logic              bit_in,
    input  logic [NB_W-1:0]   nbits,
    output logic [DATA_W-1:0] word_ext,
    output logic              reserved
);
    logic [DATA_W-1:0] raw;
    logic              sign;
    logic [DATA_W-1:0] neg_code;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            raw <= '0;
        else if (clr)
            raw <= '0;
        else if (shift_en)
            raw <= {raw[DATA_W-2:0], bit_in};
    end

    assign sign     = raw[nbits - 1'b1];
    assign neg_code = DATA_W'(1) << (nbits - 1'b1);
    assign reserved = (raw == neg_code);

    for (genvar i = 0; i < DATA_W; i++) begin : g_ext
        assign word_ext[i] = (NB_W'(i) < nbits) ? raw[i] : sign;
    end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
    import adc_host_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int MIN_RES  = 10,
    parameter int HP_W     = 16,
    parameter int TO_W     = 24,
    parameter int MIN_HALF = 188
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_start,
    input  logic                         cmd_resync,
    input  logic [1:0]                   cmd_chan,
    input  logic [$clog2(DATA_W+1)-1:0]  cmd_res,
    input  logic [HP_W-1:0]              half_period,
    input  logic [TO_W-1:0]              timeout_limit,
    output logic                         adc_sclk,
    output logic [1:0]                   adc_addr,
    input  logic                         adc_sdat,
    output logic                         busy,
    output logic [DATA_W-1:0]            rslt_data,
    output logic                         rslt_valid,
    output logic                         rslt_bad,
    output logic                         tmo_err,
    output logic                         sync_found
);
    localparam int NB_W    = $clog2(DATA_W + 1);
    localparam int MAX_RED = DATA_W - MIN_RES;
    localparam int RED_W   = $clog2(MAX_RED + 1);
    localparam int PL_W    = HP_W + 1;
    localparam logic [NB_W-1:0] RES_LO = NB_W'(MIN_RES);
    localparam logic [NB_W-1:0] RES_HI = NB_W'(DATA_W);

    host_st_e          state, nxt;
    logic [NB_W-1:0]   nbits, bits_left, res_c;
    logic [RED_W-1:0]  red_left;
    logic [1:0]        addr_q;
    logic              h0, lsmp, rs_mode, found;
    logic              tm_load, tm_done, to_clr, to_en, to_exp;
    logic              sh_clr, sh_en, sh_res;
    logic [DATA_W-1:0] sh_word;
    logic              rs_state;

    assign res_c = (cmd_res < RES_LO) ? RES_LO :
                   (cmd_res > RES_HI) ? RES_HI : cmd_res;
    assign found    = ({h0, lsmp, adc_sdat} == 3'b110);
    assign rs_state = (state == ST_RS_HI0) || (state == ST_RS_LO) || (state == ST_RS_HI);

    adc_host_phase_timer #(.HP_W(HP_W), .MIN_HALF(MIN_HALF)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(tm_load),
        .half_period(half_period), .expired(tm_done)
    );

    adc_host_timeout #(.TO_W(TO_W)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(to_clr), .en(to_en),
        .limit(timeout_limit), .expired(to_exp)
    );

    adc_host_shifter #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .clr(sh_clr), .shift_en(sh_en),
        .bit_in(adc_sdat), .nbits(nbits), .word_ext(sh_word), .reserved(sh_res)
    );

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (cmd_start) nxt = ST_SETUP;
                         else if (cmd_resync) nxt = ST_RS_HI0;
            ST_SETUP:    if (tm_done) nxt = ST_START_LO;
            ST_START_LO: if (tm_done) nxt = ST_RED_HI;
            ST_RED_HI:   if (tm_done) nxt = (red_left != '0) ? ST_RED_LO : ST_WAIT;
            ST_RED_LO:   if (tm_done) nxt = ST_RED_HI;
            ST_WAIT:     if (adc_sdat) nxt = ST_RD_LO;
                         else if (to_exp) nxt = ST_IDLE;
            ST_RD_LO:    if (tm_done) nxt = ST_RD_HI;
            ST_RD_HI:    if (tm_done) nxt = (bits_left == '0) ? ST_DONE : ST_RD_LO;
            ST_DONE:     nxt = ST_IDLE;
            ST_RS_HI0:   if (to_exp) nxt = ST_IDLE;
                         else if (tm_done) nxt = ST_RS_LO;
            ST_RS_LO:    if (to_exp) nxt = ST_IDLE;
                         else if (tm_done) nxt = ST_RS_HI;
            ST_RS_HI:    if (to_exp) nxt = ST_IDLE;
                         else if (tm_done) nxt = found ? ST_WAIT : ST_RS_LO;
            default:     nxt = ST_IDLE;
        endcase
    end

    assign tm_load = (nxt != state);
    assign to_clr  = (state == ST_IDLE) || ((nxt == ST_WAIT) && (state != ST_WAIT));
    assign to_en   = (state == ST_WAIT) || rs_state;
    assign sh_clr  = (state == ST_IDLE);
    assign sh_en   = (state == ST_RD_LO) && tm_done;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end

    // pin outputs
    always_comb begin
        adc_sclk = !((state == ST_START_LO) || (state == ST_RED_LO) ||
                     (state == ST_RD_LO)    || (state == ST_RS_LO));
        busy     = (state != ST_IDLE);
        adc_addr = addr_q;
    end

    // registered outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            nbits      <= RES_HI;
            bits_left  <= '0;
            red_left   <= '0;
            h0         <= 1'b0;
            lsmp       <= 1'b0;
            rs_mode    <= 1'b0;
            rslt_data  <= '0;
            rslt_valid <= 1'b0;
            rslt_bad   <= 1'b0;
            tmo_err    <= 1'b0;
            sync_found <= 1'b0;
        end else begin
            rslt_valid <= 1'b0;
            tmo_err    <= 1'b0;
            sync_found <= 1'b0;
            if (state == ST_IDLE) begin
                if (cmd_start) begin
                    addr_q   <= cmd_chan;
                    nbits    <= res_c;
                    red_left <= RED_W'(RES_HI - res_c);
                    rs_mode  <= 1'b0;
                end else if (cmd_resync) begin
                    nbits    <= RES_HI;
                    red_left <= '0;
                    rs_mode  <= 1'b1;
                end
            end
            if ((state == ST_RED_LO) && tm_done)
                red_left <= red_left - 1'b1;
            if ((nxt == ST_WAIT) && (state != ST_WAIT))
                bits_left <= nbits;
            if (sh_en)
                bits_left <= bits_left - 1'b1;
            if ((state == ST_RS_HI0) && tm_done)
                h0 <= adc_sdat;
            if ((state == ST_RS_LO) && tm_done)
                lsmp <= adc_sdat;
            if ((state == ST_RS_HI) && tm_done && !to_exp) begin
                if (found)
                    sync_found <= 1'b1;
                else
                    h0 <= adc_sdat;
            end
            if (((state == ST_WAIT) && !adc_sdat && to_exp) || (rs_state && to_exp))
                tmo_err <= 1'b1;
            if (state == ST_DONE) begin
                rslt_data  <= sh_word;
                rslt_bad   <= sh_res;
                rslt_valid <= 1'b1;
            end
        end
    end

    // observation logic for checks
    logic            sclk_d;
    logic [PL_W-1:0] ph_len;
    logic [4:0]      fall_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d   <= 1'b1;
            ph_len   <= '0;
            fall_cnt <= '0;
        end else begin
            sclk_d <= adc_sclk;
            if (adc_sclk != sclk_d)
                ph_len <= PL_W'(1);
            else if (ph_len != '1)
                ph_len <= ph_len + 1'b1;
            if (state == ST_IDLE)
                fall_cnt <= '0;
            else if (sclk_d && !adc_sclk && (fall_cnt != '1))
                fall_cnt <= fall_cnt + 1'b1;
        end
    end

    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(adc_addr));

    assert_red_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        red_left <= RED_W'(MAX_RED));

    assert_phase_min_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_sclk != sclk_d) |-> (ph_len >= PL_W'(MIN_HALF)));

    assert_edges_17_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rslt_valid && !rs_mode) |-> (fall_cnt == 5'(DATA_W + 1)));

    assert_tmo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_err |-> (!busy && adc_sclk));

    assert_sext_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> (rslt_data[DATA_W-1] == rslt_data[nbits - 1'b1]));

    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rslt_valid, tmo_err, sync_found}));

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rslt_valid |-> adc_sclk);
endmodule

// File: tb/adc_host_ctrl_tb.sv
module adc_host_ctrl_tb;
    localparam int HPW = 8;
    localparam int TOW = 12;
    localparam int MINH = 4;
    localparam int WIN = 150;
    localparam int CONV_BASE = 64;

    typedef struct packed {
        logic [1:0]  ch;
        logic [4:0]  res;
        logic [7:0]  hp;
        logic [15:0] word;
        logic [15:0] exp;
        logic        bad;
        logic [4:0]  n;
    } vec_t;

    localparam vec_t VEC [0:6] = '{
        '{2'd1, 5'd16, 8'd6, 16'h1234, 16'h1234, 1'b0, 5'd16},
        '{2'd2, 5'd12, 8'd5, 16'h0A5C, 16'hFA5C, 1'b0, 5'd12},
        '{2'd3, 5'd10, 8'd4, 16'h0155, 16'h0155, 1'b0, 5'd10},
        '{2'd0, 5'd7,  8'd2, 16'h0200, 16'hFE00, 1'b1, 5'd10},
        '{2'd1, 5'd20, 8'd4, 16'h8000, 16'h8000, 1'b1, 5'd16},
        '{2'd2, 5'd13, 8'd7, 16'h1FFF, 16'hFFFF, 1'b0, 5'd13},
        '{2'd0, 5'd14, 8'd4, 16'h2001, 16'hE001, 1'b0, 5'd14}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_start = 1'b0, cmd_resync = 1'b0;
    logic [1:0] cmd_chan = '0;
    logic [4:0] cmd_res = 5'd16;
    logic [HPW-1:0] half_period = 8'd4;
    logic [TOW-1:0] timeout_limit = 12'd2000;
    logic adc_sclk, adc_sdat, busy, rslt_valid, rslt_bad, tmo_err, sync_found;
    logic [1:0] adc_addr;
    logic [15:0] rslt_data;

    always #2 clk = ~clk;

    adc_host_ctrl #(.DATA_W(16), .MIN_RES(10), .HP_W(HPW), .TO_W(TOW), .MIN_HALF(MINH)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_resync(cmd_resync),
        .cmd_chan(cmd_chan), .cmd_res(cmd_res), .half_period(half_period),
        .timeout_limit(timeout_limit), .adc_sclk(adc_sclk), .adc_addr(adc_addr),
        .adc_sdat(adc_sdat), .busy(busy), .rslt_data(rslt_data), .rslt_valid(rslt_valid),
        .rslt_bad(rslt_bad), .tmo_err(tmo_err), .sync_found(sync_found)
    );

    // converter model
    logic [15:0] nxt_word = '0;
    logic        dead = 1'b0;
    logic [1:0]  inj = 2'd0;
    logic        mreset = 1'b0;
    logic [2:0]  m_mode;
    logic        m_sdat, m_prev;
    int          m_win, m_conv, m_red, m_left;
    logic [15:0] m_sh;
    logic [1:0]  m_addr;
    int          falls, low_run, min_low;

    assign adc_sdat = m_sdat;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode <= 3'd0; m_sdat <= 1'b1; m_prev <= 1'b1;
            m_win <= 0; m_conv <= 0; m_red <= 0; m_left <= 0; m_sh <= '0; m_addr <= '0;
        end else begin
            m_prev <= adc_sclk;
            if (inj == 2'd1) begin
                m_mode <= 3'd3; m_left <= 5; m_sh <= 16'h0016; m_sdat <= 1'b1;
            end else if (inj == 2'd2) begin
                m_mode <= 3'd0; m_sdat <= 1'b1;
            end else begin
                case (m_mode)
                    3'd0: if (m_prev && !adc_sclk) begin
                        m_mode <= 3'd1; m_addr <= adc_addr; m_red <= 0;
                        m_win <= WIN; m_sdat <= 1'b1;
                    end
                    3'd1: begin
                        if (m_win == 0) begin
                            m_mode <= 3'd2; m_conv <= CONV_BASE >> m_red; m_sdat <= 1'b0;
                        end else begin
                            m_win <= m_win - 1;
                            if (!m_prev && adc_sclk) m_sdat <= 1'b0;
                            if (m_prev && !adc_sclk && m_red < 6) begin
                                m_red <= m_red + 1; m_sdat <= 1'b1;
                            end
                        end
                    end
                    3'd2: if (!dead) begin
                        if (m_conv == 0) begin
                            m_mode <= 3'd3; m_sdat <= 1'b1; m_left <= 16 - m_red; m_sh <= nxt_word;
                        end else m_conv <= m_conv - 1;
                    end
                    3'd3: begin
                        if (m_prev && !adc_sclk && m_left > 0) begin
                            m_sdat <= m_sh[m_left-1]; m_left <= m_left - 1;
                        end else if (!m_prev && adc_sclk && m_left == 0) begin
                            m_mode <= 3'd0; m_sdat <= 1'b1;
                        end
                    end
                    default: m_mode <= 3'd0;
                endcase
            end
        end
    end

    // edge and phase observation
    always @(posedge clk) begin
        if (!rst_n) begin
            falls <= 0; low_run <= 0; min_low <= 255;
        end else begin
            if (m_prev && !adc_sclk) falls <= falls + 1;
            if (!adc_sclk) low_run <= low_run + 1;
            else low_run <= 0;
            if (mreset) min_low <= 255;
            else if (adc_sclk && low_run != 0 && low_run < min_low) min_low <= low_run;
        end
    end

    int n_total = 0, n_bad = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_valid(output bit got);
        got = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (rslt_valid) begin got = 1'b1; break; end
        end
    endtask

    task automatic pulse(input bit rs);
        @(negedge clk);
        if (rs) cmd_resync = 1'b1; else cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0; cmd_resync = 1'b0;
    endtask

    task automatic clr_min();
        @(negedge clk); mreset = 1'b1;
        @(negedge clk); mreset = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_total++; n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

    initial begin
        bit got;
        int f0, span;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(adc_sclk === 1'b1, "R1 sclk after reset", adc_sclk, 1);
        chk(busy === 1'b0, "R1 busy after reset", busy, 0);
        chk(rslt_valid === 1'b0, "R7 no strobe after reset", rslt_valid, 0);

        for (int v = 0; v < 7; v++) begin
            cmd_chan = VEC[v].ch; cmd_res = VEC[v].res; half_period = VEC[v].hp;
            nxt_word = VEC[v].word;
            clr_min();
            f0 = falls;
            pulse(1'b0);
            @(negedge clk);
            chk(adc_addr == VEC[v].ch, "R2 address presented", adc_addr, VEC[v].ch);
            wait_valid(got);
            chk(got, "R5 result produced", got, 1);
            chk(rslt_data == VEC[v].exp, "R7 sign-extended result", rslt_data, VEC[v].exp);
            chk(rslt_bad == VEC[v].bad, "R8 reserved flag", rslt_bad, VEC[v].bad);
            chk(16 - m_red == int'(VEC[v].n), "R3 R4 reduction edges", 16 - m_red, VEC[v].n);
            chk(m_addr == VEC[v].ch, "R2 channel at start edge", m_addr, VEC[v].ch);
            chk(falls - f0 == 17, "R6 falling edges", falls - f0, 17);
            span = (VEC[v].hp < MINH) ? MINH : int'(VEC[v].hp);
            chk(min_low == span, "R9 phase width", min_low, span);
            @(negedge clk);
            chk(rslt_valid === 1'b0, "R7 strobe one cycle", rslt_valid, 0);
            chk(busy === 1'b0 && adc_sclk === 1'b1, "R1 idle after result", {busy, adc_sclk}, 1);
            repeat (5) @(negedge clk);
        end

        // R12: commands ignored while busy
        cmd_chan = 2'd3; cmd_res = 5'd16; half_period = 8'd4; nxt_word = 16'h0777;
        f0 = falls;
        pulse(1'b0);
        repeat (20) @(negedge clk);
        cmd_chan = 2'd1; cmd_res = 5'd10;
        pulse(1'b0);
        pulse(1'b1);
        @(negedge clk);
        chk(adc_addr == 2'd3, "R12 address kept while busy", adc_addr, 3);
        wait_valid(got);
        chk(rslt_data == 16'h0777, "R12 result unaffected", rslt_data, 16'h0777);
        chk(falls - f0 == 17, "R12 no extra edges", falls - f0, 17);
        @(negedge clk);
        chk(busy === 1'b0, "R12 ends idle", busy, 0);
        repeat (5) @(negedge clk);

        // R10 timeout
        dead = 1'b1; timeout_limit = 12'd100; cmd_res = 5'd16;
        pulse(1'b0);
        got = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (tmo_err) begin got = 1'b1; break; end
            if (rslt_valid) break;
        end
        chk(got, "R10 timeout strobe", got, 1);
        chk(adc_sclk === 1'b1 && busy === 1'b0, "R10 idle after timeout", {adc_sclk, busy}, 2);
        chk(rslt_valid === 1'b0, "R10 no result", rslt_valid, 0);
        @(negedge clk);
        chk(tmo_err === 1'b0, "R10 strobe one cycle", tmo_err, 0);
        dead = 1'b0; timeout_limit = 12'd2000;
        inj = 2'd2; @(negedge clk); inj = 2'd0;
        repeat (3) @(negedge clk);

        // R11 resync from mid-readout
        inj = 2'd1; @(negedge clk); inj = 2'd0;
        nxt_word = 16'h4321;
        pulse(1'b1);
        got = 1'b0;
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (sync_found) begin got = 1'b1; break; end
        end
        chk(got, "R11 lock found", got, 1);
        wait_valid(got);
        chk(got && rslt_data == 16'h4321, "R11 result after lock", rslt_data, 16'h4321);
        chk(m_red == 0, "R11 full resolution", m_red, 0);
        @(negedge clk);
        chk(busy === 1'b0 && adc_sclk === 1'b1, "R1 idle after resync", {busy, adc_sclk}, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule